// File: doc/BRIEF.md
# Banked Register File for a 16-bit Processor Core

This block is the register storage for a small 16-bit processor. Two complete copies of the general set exist: four data registers (D0 to D3), two address registers (X0, X1) and a frame pointer. A bank-select input chooses which copy every access uses. Both banks share a set of other registers: two 16-bit stack pointers (user and interrupt, with a select input choosing the active one), a 16-bit static base pointer, a 20-bit program counter and a 20-bit vector-table base.

One write port and two read ports share the register selection and size encodings. An access can take the low byte or the high byte of D0 or D1, a 16-bit word, or a 32-bit long. A long access on a pair uses D2:D0, D3:D1 or X1:X0. Reads are combinational from the stored state. Writes take effect at the rising clock edge. The block has no state machine: the write path is a decoded register update and each read port is a combinational selector.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous active-high `rst` clears every register to zero. A write in one cycle is seen by reads from the next cycle on, and a read in the same cycle as a write returns the old value.
- R2: With size code 0 (low byte) or 1 (high byte) on D0 (sel 0) or D1 (sel 1), a write changes only bits 7:0 or bits 15:8 respectively from `wdata[7:0]`, and the other half keeps its value. A byte read returns that half in `rdata[7:0]` with the upper bits zero.
- R3: With size code 2 (word), sel 0 to 6 (D0, D1, D2, D3, X0, X1, frame pointer), sel 7 (active stack pointer) and sel 8 (static base) write `wdata[15:0]` and read back zero-extended to 32 bits.
- R4: With size code 3 (long), sel 0 accesses D2:D0 and sel 1 accesses D3:D1, with `wdata[31:16]`/`rdata[31:16]` on the upper register.
- R5: With size code 3, sel 4 accesses X1:X0, with X1 as the upper half. A long access to sel 2, 3, 5, 6, 7 or 8 behaves as a word access.
- R6: `bank_sel` 0 routes all accesses to sel 0 to 6 to bank 0, and 1 routes them to bank 1. The other bank is left unchanged.
- R7: Sel 7 reaches the user stack pointer when `sp_user` is 1 and the interrupt stack pointer when it is 0. The other pointer is unchanged.
- R8: The stack pointers, static base, program counter and table base are shared. A value written under one bank reads back the same under the other.
- R9: Sel 9 (program counter) and sel 12 (table base) are 20 bits wide and take `wdata[19:0]` on word or long writes. Sel 10 writes or reads only table-base bits 19:16 through data bits 3:0. Sel 11 writes or reads only table-base bits 15:0. The part not addressed keeps its value.
- R10: A byte-size access to any sel other than 0 or 1, and any access to sel 13 to 15, is ignored on write and reads as zero.
- R11: The two read ports have independent sel and size inputs, and each returns its own register at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Active bank for sel 0 to 6 |
| sp_user | input | 1 | 1: user stack pointer, 0: interrupt stack pointer |
| we | input | 1 | Write enable |
| wsel | input | 4 | Write register select |
| wsize | input | 2 | Write size: 0 low byte, 1 high byte, 2 word, 3 long |
| wdata | input | 32 | Write data |
| rsel_a | input | 4 | Read port A register select |
| rsize_a | input | 2 | Read port A size |
| rdata_a | output | 32 | Read port A data |
| rsel_b | input | 4 | Read port B register select |
| rsize_b | input | 2 | Read port B size |
| rdata_b | output | 32 | Read port B data |

## Verification
A write and two reads can hit the same register in the same cycle. For example, a byte write to D0 can land while one port reads D0 as a word and the other reads D2:D0 as a long. The bench drives random write and read selections over a small register space, so such overlaps occur often. It also adds directed cases, such as a long write to D3:D1 while D1's high byte is read. Each read in the write cycle must match the bench model's state before the write, and the cycle after must show the merged value.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [1:0] {
        SZ_LO   = 2'd0,
        SZ_HI   = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } rf_size_e;

    typedef enum logic [3:0] {
        RS_D0  = 4'd0,
        RS_D1  = 4'd1,
        RS_D2  = 4'd2,
        RS_D3  = 4'd3,
        RS_X0  = 4'd4,
        RS_X1  = 4'd5,
        RS_FP  = 4'd6,
        RS_SP  = 4'd7,
        RS_SB  = 4'd8,
        RS_PC  = 4'd9,
        RS_TBH = 4'd10,
        RS_TBL = 4'd11,
        RS_TB  = 4'd12
    } rf_sel_e;

    localparam int NREG = 7;

endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [3:0]           sel,
    input  logic [1:0]           size,
    input  logic [2*DW-1:0]      wdata,
    output logic [NREG*DW-1:0]   regs_flat
);
    localparam int HW = DW / 2;

    logic [DW-1:0] r [NREG];
    logic          wide;

    assign wide = (size == SZ_WORD) || (size == SZ_LONG);

    for (genvar i = 0; i < NREG; i++) begin : g_flat
        assign regs_flat[i*DW +: DW] = r[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) r[i] <= '0;
        end else if (we) begin
            unique case (sel)
                RS_D0, RS_D1: begin
                    unique case (size)
                        SZ_LO:   r[sel[0]][HW-1:0]  <= wdata[HW-1:0];
                        SZ_HI:   r[sel[0]][DW-1:HW] <= wdata[HW-1:0];
                        SZ_WORD: r[sel[0]]          <= wdata[DW-1:0];
                        default: begin
                            r[sel[0]]     <= wdata[DW-1:0];
                            r[sel[0] + 2] <= wdata[2*DW-1:DW];
                        end
                    endcase
                end
                RS_D2: if (wide) r[2] <= wdata[DW-1:0];
                RS_D3: if (wide) r[3] <= wdata[DW-1:0];
                RS_X0: begin
                    if (wide) r[4] <= wdata[DW-1:0];
                    if (size == SZ_LONG) r[5] <= wdata[2*DW-1:DW];
                end
                RS_X1: if (wide) r[5] <= wdata[DW-1:0];
                RS_FP: if (wide) r[6] <= wdata[DW-1:0];
                default: ;
            endcase
        end
    end

    p_idle_bank_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));

    p_byte_keeps_high_r2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_D0 && size == SZ_LO) |=> $stable(r[0][DW-1:HW]));

    p_long_upper_d2_r4: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_D0 && size == SZ_LONG) |=> (r[2] == $past(wdata[2*DW-1:DW])));

    p_long_upper_x1_r5: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_X0 && size == SZ_LONG) |=> (r[5] == $past(wdata[2*DW-1:DW])));

endmodule

// File: rtl/rf_shared.sv
module rf_shared
    import rf_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    sel,
    input  logic [1:0]    size,
    input  logic [PW-1:0] wdata,
    input  logic          sp_user,
    output logic [DW-1:0] usp,
    output logic [DW-1:0] isp,
    output logic [DW-1:0] sb,
    output logic [PW-1:0] pc,
    output logic [PW-1:0] tb
);
    localparam int UW = PW - DW;

    logic wide;
    assign wide = (size == SZ_WORD) || (size == SZ_LONG);

    always_ff @(posedge clk) begin
        if (rst) begin
            usp <= '0;
            isp <= '0;
            sb  <= '0;
            pc  <= '0;
            tb  <= '0;
        end else if (we && wide) begin
            unique case (sel)
                RS_SP:  if (sp_user) usp <= wdata[DW-1:0]; else isp <= wdata[DW-1:0];
                RS_SB:  sb <= wdata[DW-1:0];
                RS_PC:  pc <= wdata;
                RS_TBH: tb[PW-1:DW] <= wdata[UW-1:0];
                RS_TBL: tb[DW-1:0]  <= wdata[DW-1:0];
                RS_TB:  tb <= wdata;
                default: ;
            endcase
        end
    end

    p_user_sp_only_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_SP && sp_user) |=> $stable(isp));

    p_irq_sp_only_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_SP && !sp_user) |=> $stable(usp));

    p_tb_upper_split_r9: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RS_TBH) |=> $stable(tb[DW-1:0]));

    p_byte_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (we && !wide) |=> ($stable(pc) && $stable(tb) && $stable(sb)));

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (usp == '0 && isp == '0 && sb == '0 && pc == '0 && tb == '0));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 20
) (
    input  logic [3:0]          sel,
    input  logic [1:0]          size,
    input  logic                sp_user,
    input  logic [NREG*DW-1:0]  bank_flat,
    input  logic [DW-1:0]       usp,
    input  logic [DW-1:0]       isp,
    input  logic [DW-1:0]       sb,
    input  logic [PW-1:0]       pc,
    input  logic [PW-1:0]       tb,
    output logic [2*DW-1:0]     rdata
);
    localparam int HW = DW / 2;

    logic [DW-1:0] r [NREG];
    logic          wide;

    for (genvar i = 0; i < NREG; i++) begin : g_unflat
        assign r[i] = bank_flat[i*DW +: DW];
    end

    assign wide = (size == SZ_WORD) || (size == SZ_LONG);

    always_comb begin
        rdata = '0;
        unique case (sel)
            RS_D0, RS_D1: begin
                unique case (size)
                    SZ_LO:   rdata[HW-1:0] = r[sel[0]][HW-1:0];
                    SZ_HI:   rdata[HW-1:0] = r[sel[0]][DW-1:HW];
                    SZ_WORD: rdata[DW-1:0] = r[sel[0]];
                    default: rdata = {r[sel[0] + 2], r[sel[0]]};
                endcase
            end
            RS_D2:  if (wide) rdata[DW-1:0] = r[2];
            RS_D3:  if (wide) rdata[DW-1:0] = r[3];
            RS_X0:  begin
                if (size == SZ_LONG) rdata = {r[5], r[4]};
                else if (wide)       rdata[DW-1:0] = r[4];
            end
            RS_X1:  if (wide) rdata[DW-1:0] = r[5];
            RS_FP:  if (wide) rdata[DW-1:0] = r[6];
            RS_SP:  if (wide) rdata[DW-1:0] = sp_user ? usp : isp;
            RS_SB:  if (wide) rdata[DW-1:0] = sb;
            RS_PC:  if (wide) rdata[PW-1:0] = pc;
            RS_TBH: if (wide) rdata[PW-DW-1:0] = tb[PW-1:DW];
            RS_TBL: if (wide) rdata[DW-1:0] = tb[DW-1:0];
            RS_TB:  if (wide) rdata[PW-1:0] = tb;
            default: ;
        endcase
    end

    always_comb begin
        if (!wide && sel > 4'd1) begin
            p_byte_other_zero_r10: assert (rdata == '0);
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int PW    = 20,
    parameter int NBANK = 2,
    localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BSW-1:0]    bank_sel,
    input  logic              sp_user,
    input  logic              we,
    input  logic [3:0]        wsel,
    input  logic [1:0]        wsize,
    input  logic [2*DW-1:0]   wdata,
    input  logic [3:0]        rsel_a,
    input  logic [1:0]        rsize_a,
    output logic [2*DW-1:0]   rdata_a,
    input  logic [3:0]        rsel_b,
    input  logic [1:0]        rsize_b,
    output logic [2*DW-1:0]   rdata_b
);
    logic [NREG*DW-1:0] bank_flat [NBANK];
    logic [NREG*DW-1:0] act_flat;
    logic [DW-1:0]      usp, isp, sb;
    logic [PW-1:0]      pc, tb;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rf_bank #(.DW(DW)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .we        (we && (bank_sel == BSW'(b))),
            .sel       (wsel),
            .size      (wsize),
            .wdata     (wdata),
            .regs_flat (bank_flat[b])
        );
    end

    assign act_flat = bank_flat[bank_sel];

    rf_shared #(.DW(DW), .PW(PW)) u_shared (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .sel     (wsel),
        .size    (wsize),
        .wdata   (wdata[PW-1:0]),
        .sp_user (sp_user),
        .usp     (usp),
        .isp     (isp),
        .sb      (sb),
        .pc      (pc),
        .tb      (tb)
    );

    rf_read_port #(.DW(DW), .PW(PW)) u_port_a (
        .sel (rsel_a), .size (rsize_a), .sp_user (sp_user), .bank_flat (act_flat),
        .usp (usp), .isp (isp), .sb (sb), .pc (pc), .tb (tb), .rdata (rdata_a)
    );

    rf_read_port #(.DW(DW), .PW(PW)) u_port_b (
        .sel (rsel_b), .size (rsize_b), .sp_user (sp_user), .bank_flat (act_flat),
        .usp (usp), .isp (isp), .sb (sb), .pc (pc), .tb (tb), .rdata (rdata_b)
    );

    p_write_then_read_r1: assert property (@(posedge clk) disable iff (rst)
        (we && wsel == RS_SB && wsize == SZ_WORD) |=>
        (rsel_a != RS_SB || rsize_a != SZ_WORD || rdata_a == {{DW{1'b0}}, $past(wdata[DW-1:0])}));

    p_ports_agree_r11: assert property (@(posedge clk) disable iff (rst)
        (rsel_a == rsel_b && rsize_a == rsize_b) |-> (rdata_a == rdata_b));

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [0:0]  bank_sel;
    logic        sp_user;
    logic        we;
    logic [3:0]  wsel, rsel_a, rsel_b;
    logic [1:0]  wsize, rsize_a, rsize_b;
    logic [31:0] wdata, rdata_a, rdata_b;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] mb [2][7];
    logic [15:0] m_usp, m_isp, m_sb;
    logic [19:0] m_pc, m_tb;

    always #10 clk = ~clk;

    banked_regfile u_dut (
        .clk (clk), .rst (rst), .bank_sel (bank_sel), .sp_user (sp_user),
        .we (we), .wsel (wsel), .wsize (wsize), .wdata (wdata),
        .rsel_a (rsel_a), .rsize_a (rsize_a), .rdata_a (rdata_a),
        .rsel_b (rsel_b), .rsize_b (rsize_b), .rdata_b (rdata_b)
    );

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 7; i++) mb[b][i] = '0;
        m_usp = '0; m_isp = '0; m_sb = '0; m_pc = '0; m_tb = '0;
    endtask

    function automatic logic [31:0] exp_read(int s, int z, int b, bit u);
        logic [31:0] v;
        v = '0;
        case (s)
            0, 1: case (z)
                0: v = {24'h0, mb[b][s][7:0]};
                1: v = {24'h0, mb[b][s][15:8]};
                2: v = {16'h0, mb[b][s]};
                default: v = {mb[b][s+2], mb[b][s]};
            endcase
            2, 3, 5, 6: if (z >= 2) v = {16'h0, mb[b][s]};
            4: if (z == 3) v = {mb[b][5], mb[b][4]}; else if (z == 2) v = {16'h0, mb[b][4]};
            7: if (z >= 2) v = {16'h0, (u ? m_usp : m_isp)};
            8: if (z >= 2) v = {16'h0, m_sb};
            9: if (z >= 2) v = {12'h0, m_pc};
            10: if (z >= 2) v = {28'h0, m_tb[19:16]};
            11: if (z >= 2) v = {16'h0, m_tb[15:0]};
            12: if (z >= 2) v = {12'h0, m_tb};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_write(int s, int z, int b, bit u, logic [31:0] d);
        case (s)
            0, 1: case (z)
                0: mb[b][s][7:0] = d[7:0];
                1: mb[b][s][15:8] = d[7:0];
                2: mb[b][s] = d[15:0];
                default: begin mb[b][s] = d[15:0]; mb[b][s+2] = d[31:16]; end
            endcase
            2, 3, 5, 6: if (z >= 2) mb[b][s] = d[15:0];
            4: if (z >= 2) begin
                mb[b][4] = d[15:0];
                if (z == 3) mb[b][5] = d[31:16];
            end
            7: if (z >= 2) begin if (u) m_usp = d[15:0]; else m_isp = d[15:0]; end
            8: if (z >= 2) m_sb = d[15:0];
            9: if (z >= 2) m_pc = d[19:0];
            10: if (z >= 2) m_tb[19:16] = d[3:0];
            11: if (z >= 2) m_tb[15:0] = d[15:0];
            12: if (z >= 2) m_tb = d[19:0];
            default: ;
        endcase
    endtask

    // One cycle: drive at negedge, compare both ports mid-low-phase, commit the model at posedge.
    task automatic step(bit w, int ws, int wz, logic [31:0] wd,
                        int ra, int za, int rb, int zb, int b, bit u, string tag);
        logic [31:0] ea, eb;
        @(negedge clk);
        we = w; wsel = 4'(ws); wsize = 2'(wz); wdata = wd;
        rsel_a = 4'(ra); rsize_a = 2'(za); rsel_b = 4'(rb); rsize_b = 2'(zb);
        bank_sel = 1'(b); sp_user = u;
        #5;
        ea = exp_read(ra, za, b, u);
        eb = exp_read(rb, zb, b, u);
        n_vec++;
        if (rdata_a !== ea) begin
            n_fail++;
            $display("FAIL %s port A sel=%0d size=%0d: got %h expected %h", tag, ra, za, rdata_a, ea);
        end
        n_vec++;
        if (rdata_b !== eb) begin
            n_fail++;
            $display("FAIL %s port B sel=%0d size=%0d: got %h expected %h", tag, rb, zb, rdata_b, eb);
        end
        @(posedge clk);
        if (w) model_write(ws, wz, b, u, wd);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1; we = 1'b0; wsel = '0; wsize = '0; wdata = '0;
        rsel_a = '0; rsize_a = '0; rsel_b = '0; rsize_b = '0;
        bank_sel = '0; sp_user = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state is zero on all sels
        step(0, 0, 2, 0, 0, 3, 12, 2, 0, 0, "R1 reset");
        step(0, 0, 2, 0, 7, 2, 9, 2, 1, 1, "R1 reset");
        // R2: byte writes to D0 halves; R1 old value in same cycle
        step(1, 0, 2, 32'h0000_1234, 0, 2, 0, 0, 0, 0, "R1 same-cycle");
        step(1, 0, 0, 32'h0000_00AB, 0, 2, 0, 1, 0, 0, "R2 pre-byte");
        step(1, 0, 1, 32'h0000_00CD, 0, 2, 0, 0, 0, 0, "R2 low byte kept high");
        step(1, 1, 1, 32'h0000_0077, 0, 2, 0, 1, 0, 0, "R2 high byte");
        step(0, 0, 2, 0, 1, 1, 1, 2, 0, 0, "R2 D1 high");
        // R4: long on D3:D1 while D1 high byte is read
        step(1, 1, 3, 32'hBEEF_5A5A, 1, 1, 3, 2, 0, 0, "R4 long write cycle");
        step(0, 0, 2, 0, 1, 3, 3, 2, 0, 0, "R4 D3:D1");
        step(1, 0, 3, 32'h1111_2222, 0, 3, 2, 2, 0, 0, "R4 D2:D0");
        step(0, 0, 2, 0, 0, 3, 2, 2, 0, 0, "R4 D2:D0 readback");
        // R5: X1:X0 long and word
        step(1, 4, 3, 32'hA1A1_A0A0, 4, 3, 5, 2, 0, 0, "R5 pre");
        step(1, 5, 3, 32'hFFFF_0F0F, 4, 3, 5, 3, 0, 0, "R5 X1:X0");
        step(0, 0, 2, 0, 4, 3, 5, 2, 0, 0, "R5 long-as-word on X1");
        // R3: word on frame pointer, static base
        step(1, 6, 2, 32'h0000_6666, 6, 2, 8, 2, 0, 0, "R3 pre");
        step(1, 8, 2, 32'h0000_8888, 6, 2, 8, 2, 0, 0, "R3 FP");
        // R6: bank 1 isolated from bank 0
        step(1, 0, 2, 32'h0000_9999, 0, 2, 6, 2, 1, 0, "R6 bank1 empty");
        step(0, 0, 2, 0, 0, 2, 6, 2, 0, 0, "R6 bank0 untouched");
        step(0, 0, 2, 0, 0, 2, 8, 2, 1, 0, "R6 R8 bank1 sees shared SB");
        // R7: stack pointer select
        step(1, 7, 2, 32'h0000_7001, 7, 2, 7, 2, 0, 1, "R7 pre");
        step(1, 7, 2, 32'h0000_7002, 7, 2, 7, 2, 1, 0, "R7 user");
        step(0, 0, 2, 0, 7, 2, 7, 2, 0, 0, "R7 R8 interrupt");
        step(0, 0, 2, 0, 7, 2, 7, 2, 1, 1, "R7 R8 user");
        // R9: PC and table base split
        step(1, 9, 2, 32'hFFFF_FFFF, 9, 2, 12, 2, 0, 0, "R9 pre");
        step(1, 12, 3, 32'h000A_BCDE, 9, 2, 12, 2, 0, 0, "R9 PC 20 bit");
        step(1, 10, 2, 32'h0000_0003, 10, 2, 11, 2, 0, 0, "R9 TB");
        step(1, 11, 2, 32'h0000_1357, 12, 2, 10, 2, 0, 0, "R9 TB upper only");
        step(0, 0, 2, 0, 12, 2, 11, 3, 1, 0, "R9 R8 TB lower");
        // R10: ignored byte writes and reserved codes
        step(1, 2, 0, 32'h0000_00EE, 2, 0, 9, 1, 0, 0, "R10 byte read zero");
        step(1, 14, 2, 32'hFFFF_FFFF, 2, 2, 14, 2, 0, 0, "R10 byte write ignored");
        step(1, 9, 1, 32'h0000_0055, 9, 2, 13, 3, 0, 0, "R10 reserved");
        step(0, 0, 2, 0, 9, 2, 15, 2, 0, 0, "R10 PC byte ignored");

        // R11: random traffic with both ports reading independently
        for (int k = 0; k < 3000; k++) begin
            step(1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 3), $urandom,
                 $urandom_range(0, 15), $urandom_range(0, 3),
                 $urandom_range(0, 15), $urandom_range(0, 3),
                 $urandom_range(0, 1), 1'($urandom_range(0, 1)), "R11 random");
        end

        // R1: reset clears after traffic
        @(negedge clk) rst = 1'b1; we = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk) rst = 1'b0;
        step(0, 0, 2, 0, 0, 3, 12, 2, 1, 1, "R1 reset again");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule